// File: doc/BRIEF.md
# Synchronous Burst SRAM Datapath

This block is a small synchronous static memory with a two-bit burst address counter. Commands are sampled on the rising clock edge. A cycle with chip enable high either loads a fresh address (`start`), steps to the next word of the current burst (`adv`), or repeats the current word. The write controls, sampled in the same cycle, decide whether that cycle is a write or a read. Writes can target selected byte lanes through a byte-write enable and per-lane strobes. A global write stores every lane whatever the lane controls are.

A strap input, `pipe_mode`, picks how reads come out. In flow-through mode the output register is bypassed: the first word appears after the edge that samples the address, giving a 2-1-1-1 burst. In pipelined mode the data passes through one more rising-edge register, giving 3-1-1-1. Deselects and writes travel down the same valid pipeline as reads, so in pipelined mode the bus is released one cycle after the deselect, not at once. The tri-state bus is modelled as `din`, `dout` and a drive flag. The output enable and the sleep input act on that flag without waiting for the clock. Sleep also blocks every command while it is high, and the memory keeps its contents.

Top module: `sbsram_core`

## Requirements
- R1: With `pipe_mode`=0, a read command sampled at edge N shows its word on `dout`, with `dout_drive` high, right after edge N.
- R2: With `pipe_mode`=1, a read sampled at edge N shows its word right after edge N+1. After edge N alone, `dout_drive` still reflects the command before it.
- R3: `start`=1 loads `addr`. `adv`=1 (with `start`=0) addresses the next word: the low 2 address bits count up modulo 4 and the upper bits stay fixed. `ce`=1 with neither `start` nor `adv` repeats the current word.
- R4: With `gwrite`=0, `bwe`=1 writes lane b (bits 8b+7:8b) from `din` wherever `strb[b]`=1, and leaves the other lanes unchanged. `bwe`=0, or `bwe`=1 with no strobe set, is a read.
- R5: `gwrite`=1 writes all lanes regardless of `bwe` and `strb`.
- R6: A deselect (`ce`=0) or a write sampled at edge N drops `dout_drive` after edge N in flow-through mode and after edge N+1 in pipelined mode. The previous read stays driven until then.
- R7: `oe`=0 forces `dout_drive` low at once, without a clock edge and whatever the pipeline holds. Raising `oe` again restores the drive.
- R8: `sleep`=1 forces `dout_drive` low at once and blocks all commands, so writes are dropped. The stored words are kept.
- R9: A synchronous active-high `rst` clears the output pipeline (`dout_drive`=0) and the burst address. A following repeat command (`ce`=1, `start`=0, `adv`=0) therefore reads word 0.
- R10: A write completes in its own cycle. A read in the very next cycle returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pipe_mode | input | 1 | 1 = pipelined reads, 0 = flow-through reads |
| ce | input | 1 | Chip enable; low is a deselect |
| start | input | 1 | Load `addr` as a new burst start |
| adv | input | 1 | Advance to the next burst word |
| addr | input | AW | External word address |
| bwe | input | 1 | Byte-write enable |
| strb | input | NB | Per-lane write strobes |
| gwrite | input | 1 | Global write of all lanes |
| din | input | NB*8 | Write data |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous sleep; blocks commands, keeps contents |
| dout | output | NB*8 | Read data |
| dout_drive | output | 1 | High when the bus would be driven |

## Verification
The bench builds the block with a 5-bit address and four byte lanes, which gives 32 words of 32 bits. With four lanes, masks such as 0001 and 1010 leave a lane written next to a lane that must keep its old value. 32 words leave room to fill every address with its own known pattern and still pick a burst whose start wraps within its group of four. These sizes are enough to show the two read latencies, the one-cycle-late release after a deselect or write, and the immediate effect of output enable and sleep at the ports.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sb_op_e;

  localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/sbsram_burst.sv
module sbsram_burst #(
  parameter int unsigned AW = 6,
  parameter int unsigned BB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          start,
  input  logic          adv,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_cur
);
  localparam int unsigned HW = AW - BB;

  logic [HW-1:0] base_q;
  logic [BB-1:0] off_q;

  always_comb begin
    if (start) begin
      addr_cur = addr_in;
    end else if (adv) begin
      addr_cur = {base_q, off_q + BB'(1)};
    end else begin
      addr_cur = {base_q, off_q};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      off_q  <= '0;
    end else if (accept) begin
      base_q <= addr_cur[AW-1:BB];
      off_q  <= addr_cur[BB-1:0];
    end
  end
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int unsigned AW = 6,
  parameter int unsigned NB = 2,
  parameter int unsigned LW = 8
) (
  input  logic             clk,
  input  logic             en,
  input  logic [AW-1:0]    addr,
  input  logic [NB-1:0]    lane_we,
  input  logic [NB*LW-1:0] wdata,
  output logic [NB*LW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    logic [LW-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (en) begin
        if (lane_we[b]) begin
          mem[addr] <= wdata[b*LW +: LW];
        end
        rd_q <= mem[addr];
      end
    end

    assign rdata[b*LW +: LW] = rd_q;
  end
endmodule

// File: rtl/sbsram_outpipe.sv
module sbsram_outpipe #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pipe_mode,
  input  logic          rd_cmd,
  input  logic [DW-1:0] rd_data,
  input  logic          oe,
  input  logic          sleep,
  output logic [DW-1:0] dout,
  output logic          dout_drive
);
  logic          v1_q;
  logic          v2_q;
  logic [DW-1:0] out_q;
  logic          stage_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q  <= 1'b0;
      v2_q  <= 1'b0;
      out_q <= '0;
    end else begin
      v1_q  <= rd_cmd;
      v2_q  <= v1_q;
      out_q <= rd_data;
    end
  end

  assign stage_valid = pipe_mode ? v2_q : v1_q;
  assign dout        = pipe_mode ? out_q : rd_data;
  assign dout_drive  = oe && !sleep && stage_valid;
endmodule

// File: rtl/sbsram_core.sv
module sbsram_core #(
  parameter int unsigned AW = 6,
  parameter int unsigned NB = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             pipe_mode,
  input  logic                             ce,
  input  logic                             start,
  input  logic                             adv,
  input  logic [AW-1:0]                    addr,
  input  logic                             bwe,
  input  logic [NB-1:0]                    strb,
  input  logic                             gwrite,
  input  logic [NB*sbsram_pkg::LANE_W-1:0] din,
  input  logic                             oe,
  input  logic                             sleep,
  output logic [NB*sbsram_pkg::LANE_W-1:0] dout,
  output logic                             dout_drive
);
  import sbsram_pkg::*;

  localparam int unsigned DW = NB * LANE_W;
  localparam int unsigned BB = 2;

  logic          accept;
  logic [AW-1:0] addr_cur;
  logic [NB-1:0] lane_we;
  logic [DW-1:0] rd_data;
  sb_op_e        op;

  assign accept = ce && !sleep && !rst;

  always_comb begin
    if (!accept) begin
      op = OP_NONE;
    end else if (gwrite || (bwe && (|strb))) begin
      op = OP_WRITE;
    end else begin
      op = OP_READ;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_we
    assign lane_we[b] = (op == OP_WRITE) && (gwrite || (bwe && strb[b]));
  end

  sbsram_burst #(.AW(AW), .BB(BB)) burst_i (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .start    (start),
    .adv      (adv),
    .addr_in  (addr),
    .addr_cur (addr_cur)
  );

  sbsram_array #(.AW(AW), .NB(NB), .LW(LANE_W)) array_i (
    .clk     (clk),
    .en      (accept),
    .addr    (addr_cur),
    .lane_we (lane_we),
    .wdata   (din),
    .rdata   (rd_data)
  );

  sbsram_outpipe #(.DW(DW)) outpipe_i (
    .clk        (clk),
    .rst        (rst),
    .pipe_mode  (pipe_mode),
    .rd_cmd     (op == OP_READ),
    .rd_data    (rd_data),
    .oe         (oe),
    .sleep      (sleep),
    .dout       (dout),
    .dout_drive (dout_drive)
  );
endmodule

// File: rtl/sbsram_core_chk.sv
module sbsram_core_chk #(
  parameter int unsigned NB = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          pipe_mode,
  input logic          ce,
  input logic          bwe,
  input logic [NB-1:0] strb,
  input logic          gwrite,
  input logic          oe,
  input logic          sleep,
  input logic          dout_drive
);
  logic wr_c;
  logic rd_c;

  assign wr_c = ce && !sleep && (gwrite || (bwe && (|strb)));
  assign rd_c = ce && !sleep && !wr_c;

  assert_ft_read_drive_R1: assert property (@(posedge clk) disable iff (rst)
    (!pipe_mode && oe && !sleep && $past(!rst) && $past(rd_c)) |-> dout_drive);

  assert_pipe_read_drive_R2: assert property (@(posedge clk) disable iff (rst)
    (pipe_mode && oe && !sleep && $past(!rst) && $past(!rst, 2) && $past(rd_c, 2))
      |-> dout_drive);

  assert_ft_deselect_R6: assert property (@(posedge clk) disable iff (rst)
    (!pipe_mode && $past(!ce)) |-> !dout_drive);

  assert_dcd_release_R6: assert property (@(posedge clk) disable iff (rst)
    (pipe_mode && $past(!ce, 2)) |-> !dout_drive);

  assert_write_release_R6: assert property (@(posedge clk) disable iff (rst)
    (pipe_mode && $past(wr_c, 2)) |-> !dout_drive);

  assert_oe_off_R7: assert property (@(posedge clk) disable iff (rst)
    !oe |-> !dout_drive);

  assert_sleep_off_R8: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !dout_drive);
endmodule

bind sbsram_core sbsram_core_chk #(.NB(NB)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .pipe_mode  (pipe_mode),
  .ce         (ce),
  .bwe        (bwe),
  .strb       (strb),
  .gwrite     (gwrite),
  .oe         (oe),
  .sleep      (sleep),
  .dout_drive (dout_drive)
);

// File: tb/sbsram_core_tb_top.sv
module sbsram_core_tb_top;
  localparam int unsigned AW = 5;
  localparam int unsigned NB = 4;
  localparam int unsigned DW = NB * 8;
  localparam int NVEC = 7;

  // {addr[5], bwe, strb[4], gwrite, din[32], expected[32]}
  localparam logic [74:0] VEC [NVEC] = '{
    {5'd3, 1'b1, 4'b0001, 1'b0, 32'h12345678, 32'hC0DE0078},
    {5'd4, 1'b1, 4'b1010, 1'b0, 32'hAABBCCDD, 32'hAADECC04},
    {5'd5, 1'b0, 4'b0000, 1'b1, 32'h0BADF00D, 32'h0BADF00D},
    {5'd6, 1'b1, 4'b0001, 1'b1, 32'h11223344, 32'h11223344},
    {5'd7, 1'b0, 4'b1111, 1'b0, 32'hFFFFFFFF, 32'hC0DE0007},
    {5'd8, 1'b1, 4'b0000, 1'b0, 32'hFFFFFFFF, 32'hC0DE0008},
    {5'd9, 1'b1, 4'b1111, 1'b0, 32'h89ABCDEF, 32'h89ABCDEF}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pipe_mode = 1'b0;
  logic          ce = 1'b0;
  logic          start = 1'b0;
  logic          adv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          bwe = 1'b0;
  logic [NB-1:0] strb = '0;
  logic          gwrite = 1'b0;
  logic [DW-1:0] din = '0;
  logic          oe = 1'b1;
  logic          sleep = 1'b0;
  logic [DW-1:0] dout;
  logic          dout_drive;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sbsram_core #(.AW(AW), .NB(NB)) dut_i (
    .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .ce(ce), .start(start),
    .adv(adv), .addr(addr), .bwe(bwe), .strb(strb), .gwrite(gwrite),
    .din(din), .oe(oe), .sleep(sleep), .dout(dout), .dout_drive(dout_drive)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_word(input string tag, input logic [31:0] exp);
    chk(dout_drive === 1'b1, tag, 32'(dout_drive), 32'd1);
    chk(dout === exp, tag, dout, exp);
  endtask

  task automatic put(input logic c, input logic s, input logic a,
                     input logic [AW-1:0] ad, input logic be,
                     input logic [NB-1:0] st, input logic g,
                     input logic [DW-1:0] d);
    ce = c; start = s; adv = a; addr = ad; bwe = be; strb = st;
    gwrite = g; din = d;
  endtask

  task automatic idle();
    put(1'b0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic rd(input logic [AW-1:0] ad);
    put(1'b1, 1'b1, 1'b0, ad, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) step();
    chk(dout_drive === 1'b0, "R9 drive low in reset", 32'(dout_drive), 32'd0);
    rst = 1'b0;
    step();
    chk(dout_drive === 1'b0, "R9 drive low after reset", 32'(dout_drive), 32'd0);

    // fill every word with a known pattern by global write (R5)
    for (int a = 0; a < (1 << AW); a++) begin
      put(1'b1, 1'b1, 1'b0, AW'(a), 1'b0, '0, 1'b1, 32'hC0DE0000 + 32'(a));
      step();
    end
    idle();
    step();

    // vector table: write then read next cycle, flow-through (R4 R5 R10 R1)
    for (int i = 0; i < NVEC; i++) begin
      put(1'b1, 1'b1, 1'b0, VEC[i][74:70], VEC[i][69], VEC[i][68:65],
          VEC[i][64], VEC[i][63:32]);
      step();
      rd(VEC[i][74:70]);
      step();
      chk_word("R4/R5/R10 lane write readback", VEC[i][31:0]);
    end
    idle();
    step();

    // flow-through burst from 14: 14,15,12,13 (R1 R3)
    rd(5'd14);
    step();
    chk_word("R1 R3 first beat", 32'hC0DE000E);
    put(1'b1, 1'b0, 1'b1, '0, 1'b0, '0, 1'b0, '0);
    step();
    chk_word("R3 beat 2", 32'hC0DE000F);
    step();
    chk_word("R3 beat 3 wraps", 32'hC0DE000C);
    step();
    chk_word("R3 beat 4", 32'hC0DE000D);
    idle();
    step();
    chk(dout_drive === 1'b0, "R6 flow deselect release", 32'(dout_drive), 32'd0);

    // repeat command holds the word (R3)
    rd(5'd20);
    step();
    chk_word("R3 load 20", 32'hC0DE0014);
    put(1'b1, 1'b0, 1'b0, 5'd1, 1'b0, '0, 1'b0, '0);
    step();
    chk_word("R3 repeat holds word", 32'hC0DE0014);
    idle();
    step();

    // pipelined burst and dual-cycle deselect (R2 R6)
    pipe_mode = 1'b1;
    step();
    rd(5'd14);
    step();
    chk(dout_drive === 1'b0, "R2 no data after first edge", 32'(dout_drive), 32'd0);
    put(1'b1, 1'b0, 1'b1, '0, 1'b0, '0, 1'b0, '0);
    step();
    chk_word("R2 first beat", 32'hC0DE000E);
    step();
    chk_word("R2 beat 2", 32'hC0DE000F);
    step();
    chk_word("R2 beat 3", 32'hC0DE000C);
    idle();
    step();
    chk_word("R6 still driven after deselect", 32'hC0DE000D);
    step();
    chk(dout_drive === 1'b0, "R6 pipelined release", 32'(dout_drive), 32'd0);

    // read followed by write in pipelined mode (R6 R2)
    rd(5'd2);
    step();
    put(1'b1, 1'b1, 1'b0, 5'd30, 1'b0, '0, 1'b1, 32'h5555AAAA);
    step();
    chk_word("R2 read before write", 32'hC0DE0002);
    idle();
    step();
    chk(dout_drive === 1'b0, "R6 write releases bus", 32'(dout_drive), 32'd0);
    rd(5'd30);
    step();
    idle();
    step();
    chk_word("R2 readback of write", 32'h5555AAAA);
    step();

    // sleep (R8)
    pipe_mode = 1'b0;
    rd(5'd1);
    step();
    chk_word("R8 pre-sleep read", 32'hC0DE0001);
    sleep = 1'b1;
    #1;
    chk(dout_drive === 1'b0, "R8 sleep drops drive at once", 32'(dout_drive), 32'd0);
    put(1'b1, 1'b1, 1'b0, 5'd1, 1'b0, '0, 1'b1, 32'hDEADBEEF);
    step();
    step();
    chk(dout_drive === 1'b0, "R8 drive low while asleep", 32'(dout_drive), 32'd0);
    idle();
    sleep = 1'b0;
    rd(5'd1);
    step();
    chk_word("R8 contents kept, write dropped", 32'hC0DE0001);

    // output enable (R7)
    put(1'b1, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, '0);
    oe = 1'b0;
    #1;
    chk(dout_drive === 1'b0, "R7 oe low drops drive", 32'(dout_drive), 32'd0);
    step();
    chk(dout_drive === 1'b0, "R7 oe low over an edge", 32'(dout_drive), 32'd0);
    oe = 1'b1;
    #1;
    chk_word("R7 oe high restores", 32'hC0DE0001);

    // synchronous reset clears pipeline and burst address (R9)
    rst = 1'b1;
    step();
    chk(dout_drive === 1'b0, "R9 reset clears drive", 32'(dout_drive), 32'd0);
    rst = 1'b0;
    step();
    chk_word("R9 burst address cleared to 0", 32'hC0DE0000);
    idle();
    step();

    finish_run();
  end
endmodule